// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter channels. Each channel has a low and a high count byte, and shared mode and control registers configure it. A channel advances on cycles where the clock-enable `tickEn` is high. In timer mode it advances on every such tick. In counter mode it advances once for each high-to-low transition seen on its count pin. An optional gate lets the channel advance only while an external level is high, so the channel can measure the width of a pulse on that pin.

Each channel offers four arrangements of its two bytes:
- an 8-bit counter behind a 5-bit prescaler;
- a full 16-bit counter;
- an 8-bit counter that reloads from the high byte;
- a split arrangement, in which channel 0 becomes two independent 8-bit timers and channel 1 simply holds its count.

Each channel has an overflow flag. An acknowledge pulse from the interrupt controller clears it. Software reaches every register through a single-cycle write port and a combinational read port.

Top module: `twin_timer`

## Requirements
- R1: After reset, every register reads 00h and both `tfOut` bits are 0.
- R2: Register addresses are:
  - 0 is channel 0 low byte, 1 is channel 0 high byte, 2 is channel 1 low byte, 3 is channel 1 high byte.
  - 4 is the mode register. Channel 0 uses bits 3:0 and channel 1 uses bits 7:4. Within a nibble, bit 3 is gate, bit 2 is counter select and bits 1:0 are the mode.
  - 5 is the control register: bit 7 is flag 1, bit 6 is run 1, bit 5 is flag 0 and bit 4 is run 0. Its bits 3:0 always read 0 and ignore writes.
  - Addresses 6 and 7 read 00h.
- R3: In mode 1 each step increments the 16-bit value {high, low}. A step from FFFFh to 0000h sets the channel's flag.
- R4: In mode 0, low byte bits 4:0 form a prescaler. The high byte increments when the prescaler wraps from 31 to 0. Low byte bits 7:5 are left unchanged. The flag is set when the high byte wraps from FFh while the prescaler wraps.
- R5: In mode 2 the low byte counts up. A step from FFh loads the low byte from the high byte, leaves the high byte unchanged and sets the flag.
- R6: When channel 0 is in mode 3, its low byte is an 8-bit counter with run 0 and flag 0. Its high byte is an 8-bit timer of internal ticks that uses run 1 and flag 1. Overflows of channel 1 then do not set flag 1.
- R7: A channel 1 in mode 3 holds both of its count bytes, whatever the state of run 1.
- R8: With the gate bit set, a channel advances only while its gate pin is high and its run bit is set. With the gate pin low it holds.
- R9: In counter mode the count pin is sampled on ticks. The channel advances once on each tick where the pin is low and the previous tick's sample was high.
- R10: A write to a count byte in the same cycle as a step loads the written value. That step is dropped for the channel, with no carry and no flag. In split mode, the low-byte and high-byte timers are blocked only by writes to their own byte.
- R11: An `ackIn` pulse clears its flag. An overflow in the same cycle wins over the acknowledge. A control-register write wins over both.
- R12: No count byte changes in a cycle with `tickEn` low unless that byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Clock-enable tick that advances timers and samples count pins |
| cntPin | input | 2 | External count pins, bit n for channel n |
| gatePin | input | 2 | External gate levels, bit n for channel n |
| ackIn | input | 2 | Interrupt acknowledge pulses, bit n clears flag n |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| tfOut | output | 2 | Overflow flags, bit n is flag n |

## Verification
Two pairs of events can land in one clock and must be resolved:
- **Software load against a step.** The bench raises a write strobe to the low byte on the same edge as an enabled tick, with the 16-bit count one below a carry. It then requires the written value, an unchanged high byte and no flag.
- **Flag set against acknowledge.** The bench drives an acknowledge together with the tick that reloads a mode 2 counter from FFh, and expects the flag to remain set.

In split mode, the bench runs the channel 0 high-byte timer at the same time as channel 1 passes FFFFh. Flag 1 must then follow only the high-byte timer.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int ADDR_W = 3;
  localparam int NCH    = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_LO0 = 3'd0, A_HI0 = 3'd1, A_LO1 = 3'd2, A_HI1 = 3'd3,
    A_MODE = 3'd4, A_CTRL = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    M_PRESCALE = 2'd0, M_WIDE = 2'd1, M_RELOAD = 2'd2, M_SPLIT = 2'd3
  } mode_e;

  typedef struct packed {
    logic [NCH-1:0] step;
    logic           splitStep;
    mode_e          mode0;
    mode_e          mode1;
  } strobe_t;
endpackage

// File: rtl/tmr_datapath.sv
`timescale 1ns/1ps
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         stb,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic [BYTE_W-1:0]               wrData,
  output logic [NCH-1:0][BYTE_W-1:0]      loCnt,
  output logic [NCH-1:0][BYTE_W-1:0]      hiCnt,
  output logic [NCH-1:0]                  ovfMain,
  output logic                            ovfSplit
);
  localparam int PAIR_W = 2 * BYTE_W;

  function automatic logic [PAIR_W:0] advance(mode_e m, logic [BYTE_W-1:0] h,
                                              logic [BYTE_W-1:0] l);
    logic [PAIR_W:0] r;
    r = {1'b0, h, l};
    unique case (m)
      M_PRESCALE: begin
        if (&l[PRE_W-1:0]) begin
          r[PRE_W-1:0]             = '0;
          r[PAIR_W-1:BYTE_W]       = h + 1'b1;
          r[PAIR_W]                = &h;
        end else begin
          r[PRE_W-1:0] = l[PRE_W-1:0] + 1'b1;
        end
      end
      M_WIDE:   r = {1'b0, h, l} + 1'b1;
      M_RELOAD: begin
        if (&l) begin
          r[BYTE_W-1:0] = h;
          r[PAIR_W]     = 1'b1;
        end else begin
          r[BYTE_W-1:0] = l + 1'b1;
        end
      end
      M_SPLIT: begin
        r[BYTE_W-1:0] = l + 1'b1;
        r[PAIR_W]     = &l;
      end
      default: r = {1'b0, h, l};
    endcase
    return r;
  endfunction

  logic hiSplitGo;
  assign hiSplitGo = stb.splitStep && !(wrEn && wrAddr == A_HI0);
  assign ovfSplit  = hiSplitGo && (&hiCnt[0]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2 * c);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2 * c + 1);
    logic [BYTE_W-1:0] loR, hiR;
    mode_e             mode;
    logic              wrLo, wrHi, isSplit, doMain, doHiSplit;
    logic [PAIR_W:0]   nxt;

    assign mode      = (c == 0) ? stb.mode0 : stb.mode1;
    assign wrLo      = wrEn && wrAddr == LO_ADDR;
    assign wrHi      = wrEn && wrAddr == HI_ADDR;
    assign isSplit   = (c == 0) && mode == M_SPLIT;
    assign doMain    = stb.step[c] && !(isSplit ? wrLo : (wrLo || wrHi));
    assign doHiSplit = (c == 0) && isSplit && hiSplitGo;
    assign nxt       = advance(mode, hiR, loR);
    assign ovfMain[c] = doMain && nxt[PAIR_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loR <= '0;
        hiR <= '0;
      end else begin
        if (wrLo)        loR <= wrData;
        else if (doMain) loR <= nxt[BYTE_W-1:0];
        if (wrHi)                       hiR <= wrData;
        else if (doHiSplit)             hiR <= hiR + 1'b1;
        else if (doMain && !isSplit)    hiR <= nxt[PAIR_W-1:BYTE_W];
      end
    end

    assign loCnt[c] = loR;
    assign hiCnt[c] = hiR;
  end
endmodule

// File: rtl/tmr_control.sv
`timescale 1ns/1ps
module tmr_control
  import tmr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tickEn,
  input  logic [NCH-1:0]              cntPin,
  input  logic [NCH-1:0]              gatePin,
  input  logic [NCH-1:0]              ackIn,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BYTE_W-1:0]           wrData,
  input  logic [NCH-1:0]              ovfMain,
  input  logic                        ovfSplit,
  input  logic [NCH-1:0][BYTE_W-1:0]  loCnt,
  input  logic [NCH-1:0][BYTE_W-1:0]  hiCnt,
  output strobe_t                     stb,
  output logic [NCH-1:0]              tfOut,
  output logic [BYTE_W-1:0]           rdData,
  output logic [BYTE_W-1:0]           modeVal
);
  logic [BYTE_W-1:0] modeReg;
  logic [NCH-1:0]    trReg, tfReg, cntPrev, stepVec, setFlag;
  logic              ch0Split;

  always_comb begin
    logic [3:0] nib;
    logic       runOk, evt;
    for (int c = 0; c < NCH; c++) begin
      nib        = modeReg[4*c +: 4];
      runOk      = trReg[c] && (!nib[3] || gatePin[c]);
      evt        = tickEn && (nib[2] ? (cntPrev[c] && !cntPin[c]) : 1'b1);
      stepVec[c] = runOk && evt && !(c == 1 && nib[1:0] == M_SPLIT);
    end
  end

  assign ch0Split      = modeReg[1:0] == M_SPLIT;
  assign stb.step      = stepVec;
  assign stb.splitStep = ch0Split && trReg[1] && tickEn;
  assign stb.mode0     = mode_e'(modeReg[1:0]);
  assign stb.mode1     = mode_e'(modeReg[5:4]);

  assign setFlag[0] = ovfMain[0];
  assign setFlag[1] = ch0Split ? ovfSplit : ovfMain[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      trReg   <= '0;
      tfReg   <= '0;
      cntPrev <= '0;
    end else begin
      if (tickEn) cntPrev <= cntPin;
      if (wrEn && addr == A_MODE) modeReg <= wrData;
      if (wrEn && addr == A_CTRL) begin
        trReg <= {wrData[6], wrData[4]};
        tfReg <= {wrData[7], wrData[5]};
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (setFlag[c])    tfReg[c] <= 1'b1;
          else if (ackIn[c]) tfReg[c] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_LO0:   rdData = loCnt[0];
      A_HI0:   rdData = hiCnt[0];
      A_LO1:   rdData = loCnt[1];
      A_HI1:   rdData = hiCnt[1];
      A_MODE:  rdData = modeReg;
      A_CTRL:  rdData = {tfReg[1], trReg[1], tfReg[0], trReg[0], 4'b0000};
      default: rdData = '0;
    endcase
  end

  assign tfOut   = tfReg;
  assign modeVal = modeReg;
endmodule

// File: rtl/twin_timer.sv
`timescale 1ns/1ps
module twin_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [NCH-1:0]    cntPin,
  input  logic [NCH-1:0]    gatePin,
  input  logic [NCH-1:0]    ackIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic [NCH-1:0]    tfOut
);
  strobe_t                    stb;
  logic [NCH-1:0][BYTE_W-1:0] loCnt, hiCnt;
  logic [NCH-1:0]             ovfMain;
  logic                       ovfSplit;
  logic [BYTE_W-1:0]          modeVal;

  tmr_control u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntPin(cntPin), .gatePin(gatePin),
    .ackIn(ackIn), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .ovfMain(ovfMain), .ovfSplit(ovfSplit), .loCnt(loCnt), .hiCnt(hiCnt),
    .stb(stb), .tfOut(tfOut), .rdData(regRdData), .modeVal(modeVal)
  );

  tmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(regWrEn), .wrAddr(regAddr),
    .wrData(regWrData), .loCnt(loCnt), .hiCnt(hiCnt), .ovfMain(ovfMain),
    .ovfSplit(ovfSplit)
  );
endmodule

// File: rtl/twin_timer_chk.sv
`timescale 1ns/1ps
module twin_timer_chk
  import tmr_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       tickEn,
  input logic [NCH-1:0]             gatePin,
  input logic [NCH-1:0]             ackIn,
  input logic                       regWrEn,
  input logic [ADDR_W-1:0]          regAddr,
  input logic [BYTE_W-1:0]          regWrData,
  input logic [NCH-1:0]             tfOut,
  input logic [NCH-1:0][BYTE_W-1:0] loCnt,
  input logic [NCH-1:0][BYTE_W-1:0] hiCnt,
  input logic [NCH-1:0]             ovfMain,
  input logic [BYTE_W-1:0]          modeVal
);
  logic ctrlWr, ch0Wr, ch1Wr;
  assign ctrlWr = regWrEn && regAddr == 3'd5;
  assign ch0Wr  = regWrEn && (regAddr == 3'd0 || regAddr == 3'd1);
  assign ch1Wr  = regWrEn && (regAddr == 3'd2 || regAddr == 3'd3);

  AST_WRITE_BEATS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 3'd0 |=> loCnt[0] == $past(regWrData)); // R10
  AST_CH1_SPLIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    modeVal[5:4] == 2'b11 && !ch1Wr |=> $stable(loCnt[1]) && $stable(hiCnt[1])); // R7
  AST_GATE_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    modeVal[3] && !gatePin[0] && modeVal[1:0] != 2'b11 && !ch0Wr
    |=> $stable(loCnt[0]) && $stable(hiCnt[0])); // R8
  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ovfMain[0] && !ctrlWr |=> tfOut[0]); // R11
  AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ackIn[0] && !ovfMain[0] && !ctrlWr |=> !tfOut[0]); // R11
  AST_IDLE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn && !regWrEn |=> $stable(loCnt) && $stable(hiCnt)); // R12
endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .gatePin(gatePin), .ackIn(ackIn),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .tfOut(tfOut),
  .loCnt(loCnt), .hiCnt(hiCnt), .ovfMain(ovfMain), .modeVal(modeVal)
);

// File: tb/twin_timer_bench.sv
`timescale 1ns/1ps
module twin_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [1:0] cntPin = 2'b00;
  logic [1:0] gatePin = 2'b00;
  logic [1:0] ackIn = 2'b00;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [1:0] tfOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  twin_timer u_twin_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntPin(cntPin), .gatePin(gatePin),
    .ackIn(ackIn), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .tfOut(tfOut)
  );

  // fields: mode, preHi, preLo, ticks, expHi, expLo, expFlag0
  localparam logic [55:0] VEC [8] = '{
    56'h01_00_00_05_00_05_00,
    56'h01_00_FE_03_01_01_00,
    56'h01_FF_FE_03_00_01_01,
    56'h00_00_1E_03_01_01_00,
    56'h00_FF_FF_01_00_E0_01,
    56'h02_80_FE_03_80_81_01,
    56'h02_10_00_04_10_04_00,
    56'h03_00_FF_02_00_01_01
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1", v, 8'h00);
    end
    check("R1 flags", {6'd0, tfOut}, 8'h00);

    // R2 map details
    rd(3'd6, v); check("R2 unused addr", v, 8'h00);
    wr(3'd4, 8'hA5); rd(3'd4, v); check("R2 mode readback", v, 8'hA5);
    wr(3'd5, 8'h0F); rd(3'd5, v); check("R2 ctrl low nibble", v, 8'h00);
    wr(3'd5, 8'hF0); rd(3'd5, v); check("R2 ctrl high nibble", v, 8'hF0);
    wr(3'd5, 8'h00);

    // table of mode scenarios on channel 0
    for (int i = 0; i < 8; i++) begin
      string tag;
      logic [7:0] md;
      md = VEC[i][55:48];
      tag = (md == 8'h00) ? "R4" : (md == 8'h01) ? "R3" : (md == 8'h02) ? "R5" : "R6";
      wr(3'd5, 8'h00);
      wr(3'd4, md);
      wr(3'd1, VEC[i][47:40]);
      wr(3'd0, VEC[i][39:32]);
      wr(3'd5, 8'h10);
      ticks(int'(VEC[i][31:24]));
      rd(3'd5, v); check(tag, {7'd0, v[5]}, VEC[i][7:0]);
      rd(3'd1, v); check(tag, v, VEC[i][23:16]);
      rd(3'd0, v); check(tag, v, VEC[i][15:8]);
    end

    // R12 no change without tick
    wr(3'd5, 8'h00); wr(3'd4, 8'h01); wr(3'd0, 8'h00); wr(3'd5, 8'h10);
    repeat (5) @(negedge clk);
    rd(3'd0, v); check("R12 idle", v, 8'h00);

    // R10 write in same cycle as step
    wr(3'd5, 8'h00); wr(3'd1, 8'h07); wr(3'd0, 8'hFF); wr(3'd5, 8'h10);
    @(negedge clk);
    tickEn = 1'b1; regWrEn = 1'b1; regAddr = 3'd0; regWrData = 8'h50;
    @(negedge clk);
    tickEn = 1'b0; regWrEn = 1'b0;
    rd(3'd0, v); check("R10 low byte", v, 8'h50);
    rd(3'd1, v); check("R10 no carry", v, 8'h07);
    check("R10 no flag", {7'd0, tfOut[0]}, 8'h00);

    // R11 ack clears, overflow beats ack
    wr(3'd5, 8'h00); wr(3'd4, 8'h02); wr(3'd1, 8'h00); wr(3'd0, 8'hFF); wr(3'd5, 8'h10);
    ticks(1);
    check("R11 set", {7'd0, tfOut[0]}, 8'h01);
    @(negedge clk); ackIn = 2'b01;
    @(negedge clk); ackIn = 2'b00;
    check("R11 ack clears", {7'd0, tfOut[0]}, 8'h00);
    wr(3'd0, 8'hFF);
    @(negedge clk); tickEn = 1'b1; ackIn = 2'b01;
    @(negedge clk); tickEn = 1'b0; ackIn = 2'b00;
    check("R11 overflow beats ack", {7'd0, tfOut[0]}, 8'h01);

    // R8 gate
    wr(3'd5, 8'h00); wr(3'd4, 8'h09); wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd5, 8'h10);
    gatePin = 2'b00;
    ticks(3);
    rd(3'd0, v); check("R8 gate low holds", v, 8'h00);
    gatePin = 2'b01;
    ticks(3);
    rd(3'd0, v); check("R8 gate high counts", v, 8'h03);
    gatePin = 2'b00;

    // R9 counter mode on falling edges
    wr(3'd5, 8'h00); wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd5, 8'h10);
    @(negedge clk); tickEn = 1'b1;
    for (int k = 0; k < 8; k++) begin
      cntPin[0] = (k % 4) < 2;
      @(negedge clk);
    end
    tickEn = 1'b0; cntPin = 2'b00;
    rd(3'd0, v); check("R9 two edges", v, 8'h02);

    // R6 split high byte uses run 1 / flag 1
    wr(3'd5, 8'h00); wr(3'd4, 8'h13);
    wr(3'd1, 8'hFE); wr(3'd0, 8'h33); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd5, 8'h40);
    ticks(3);
    rd(3'd1, v); check("R6 split high", v, 8'h01);
    rd(3'd0, v); check("R6 low idle", v, 8'h33);
    rd(3'd5, v); check("R6 flag1 from split", {7'd0, v[7]}, 8'h01);
    wr(3'd5, 8'h40); wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    ticks(3);
    rd(3'd2, v); check("R6 ch1 runs", v, 8'h02);
    rd(3'd5, v); check("R6 ch1 overflow ignored", {7'd0, v[7]}, 8'h00);

    // R7 channel 1 split holds
    wr(3'd5, 8'h00); wr(3'd4, 8'h31); wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd5, 8'h40);
    ticks(4);
    rd(3'd2, v); check("R7 low hold", v, 8'h34);
    rd(3'd3, v); check("R7 high hold", v, 8'h12);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule